// File: doc/BRIEF.md
# DMA Channel Interrupt Status Collector

This block gathers the per-channel completion (terminal-count) and fault (error) events of a multi-channel DMA engine into sticky request bits and presents them to software through a small register window. Each single-cycle event pulse on a channel sets that channel's request bit. The bit stays set until software writes a one to the matching clear register. Two per-channel mask vectors select which requests software sees and which ones can raise the interrupt.

Software reads three masked views. The first holds the completion requests, the second holds the error requests, and the third is a per-channel OR of the two. Completion and error bits each have their own write-one-to-clear register. A single interrupt line is driven from the OR of every bit in the combined masked view. By default it is registered, so it follows the status one clock later. The register bus is a plain single-cycle read/write strobe interface. Read data is registered and appears after the clock edge that takes the read strobe.

Top module: `dma_irq_collector`

## Requirements
- R1: After reset all request bits are clear, `irq_out` is low and `reg_rdata` is zero.
- R2: A one on bit i of `tc_evt` or `err_evt` for one cycle sets request bit i of that kind, and the bit holds until it is cleared.
- R3: A read of offset 0x04 returns the completion request bits ANDed with `tc_mask` in bits 7:0, and zero in bits 31:8.
- R4: A read of offset 0x0C returns the error request bits ANDed with `err_mask` in bits 7:0, and zero in bits 31:8.
- R5: A read of offset 0x00 returns, per channel, the OR of the masked completion bit and the masked error bit.
- R6: A write to offset 0x08 clears each completion bit whose write-data bit is 1. Bits written 0, and write-data bits 31:8, leave the request bits unchanged.
- R7: A write to offset 0x10 clears each error bit whose write-data bit is 1. Bits written 0 leave the request bits unchanged.
- R8: When an event pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R9: A masked channel still latches its events. Its requests show in the status reads and the interrupt once its mask bit is set.
- R10: `irq_out` equals the OR of all combined masked status bits, delayed by one clock.
- R11: Reads of offsets 0x08 and 0x10, and of any unmapped offset, return zero.
- R12: Writes to offsets 0x00, 0x04 and 0x0C change no request bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe, one cycle per write |
| reg_rd_en | input | 1 | Read strobe, data registered on this edge |
| reg_addr | input | ADDR_W (5) | Byte offset of the register |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data, held until the next read |
| tc_evt | input | NUM_CH (8) | Per-channel completion event pulses |
| err_evt | input | NUM_CH (8) | Per-channel error event pulses |
| tc_mask | input | NUM_CH (8) | Per-channel completion enables |
| err_mask | input | NUM_CH (8) | Per-channel error enables |
| irq_out | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: eight channels, a 32-bit data bus and the registered interrupt variant. With a channel count below the data width, the zero-filled upper bits of each read are exercised. Because the interrupt output is registered, its one-cycle lag behind the status can be observed at both the rising and the falling transition. All eight channels are driven together, which exercises clear patterns that mix ones and zeros across the whole vector, as well as set-versus-clear collisions on one bit next to neighbours that are only set or only cleared.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

   localparam int unsigned OFS_ALL     = 32'h00;
   localparam int unsigned OFS_TC      = 32'h04;
   localparam int unsigned OFS_TC_CLR  = 32'h08;
   localparam int unsigned OFS_ERR     = 32'h0C;
   localparam int unsigned OFS_ERR_CLR = 32'h10;
   localparam int unsigned OFS_TOP     = OFS_ERR_CLR;

   typedef enum logic [2:0] {
      SEL_ALL,
      SEL_TC,
      SEL_TC_CLR,
      SEL_ERR,
      SEL_ERR_CLR,
      SEL_NONE
   } reg_sel_e;

endpackage

// File: rtl/dmairq_sticky.sv
module dmairq_sticky #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] bits_o
);

   logic [N-1:0] bits_q;

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bits_q[i] <= 1'b0;
         end else if (set_i[i]) begin
            bits_q[i] <= 1'b1;
         end else if (clr_i[i]) begin
            bits_q[i] <= 1'b0;
         end
      end

      // R2
      set_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> bits_q[i]);

      // R2
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!set_i[i] && !clr_i[i]) |=> $stable(bits_q[i]));

      // R6 R7
      clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !set_i[i]) |=> !bits_q[i]);
   end

   assign bits_o = bits_q;

endmodule

// File: rtl/dmairq_rdmux.sv
module dmairq_rdmux
   import dmairq_pkg::*;
#(
   parameter int unsigned N  = 8,
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  reg_sel_e      sel,
   input  logic [N-1:0]  tc_m,
   input  logic [N-1:0]  err_m,
   output logic [DW-1:0] rdata
);

   localparam int unsigned PAD = DW - N;

   logic [N-1:0]  view;
   logic [DW-1:0] rdata_q;
   logic [DW-1:0] rd_next;

   always_comb begin
      unique case (sel)
         SEL_ALL: view = tc_m | err_m;
         SEL_TC:  view = tc_m;
         SEL_ERR: view = err_m;
         default: view = '0;
      endcase
   end

   if (PAD == 0) begin : g_full
      assign rd_next = view;
   end else begin : g_pad
      assign rd_next = {{PAD{1'b0}}, view};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (rd_en) begin
         rdata_q <= rd_next;
      end
   end

   assign rdata = rdata_q;

   // R11
   wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (sel == SEL_TC_CLR || sel == SEL_ERR_CLR || sel == SEL_NONE))
      |=> (rdata == '0));

endmodule

// File: rtl/dmairq_irq.sv
module dmairq_irq #(
   parameter int unsigned N       = 8,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pend_i,
   output logic         irq_o
);

   logic any_pend;
   assign any_pend = |pend_i;

   if (IRQ_REG) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_q <= 1'b0;
         end else begin
            irq_q <= any_pend;
         end
      end
      assign irq_o = irq_q;

      // R10
      irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_i != '0) |=> irq_o);

      // R10
      irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_i == '0) |=> !irq_o);
   end else begin : g_comb
      assign irq_o = any_pend;
   end

endmodule

// File: rtl/dma_irq_collector.sv
module dma_irq_collector
   import dmairq_pkg::*;
#(
   parameter int unsigned NUM_CH  = 8,
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned DATA_W  = 32,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic              reg_rd_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NUM_CH-1:0] tc_evt,
   input  logic [NUM_CH-1:0] err_evt,
   input  logic [NUM_CH-1:0] tc_mask,
   input  logic [NUM_CH-1:0] err_mask,
   output logic              irq_out
);

   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   if (NUM_CH < 1 || NUM_CH > DATA_W) begin : g_bad_ch
      $error("NUM_CH must lie between 1 and DATA_W");
   end
   if (ADDR_SPAN <= OFS_TOP) begin : g_bad_addr
      $error("ADDR_W too narrow for the register window");
   end

   reg_sel_e    sel;
   logic [NUM_CH-1:0] tc_clr, err_clr;
   logic [NUM_CH-1:0] tc_raw, err_raw;
   logic [NUM_CH-1:0] tc_m, err_m;

   always_comb begin
      if      (reg_addr == ADDR_W'(OFS_ALL))     sel = SEL_ALL;
      else if (reg_addr == ADDR_W'(OFS_TC))      sel = SEL_TC;
      else if (reg_addr == ADDR_W'(OFS_TC_CLR))  sel = SEL_TC_CLR;
      else if (reg_addr == ADDR_W'(OFS_ERR))     sel = SEL_ERR;
      else if (reg_addr == ADDR_W'(OFS_ERR_CLR)) sel = SEL_ERR_CLR;
      else                                       sel = SEL_NONE;
   end

   assign tc_clr  = (reg_wr_en && sel == SEL_TC_CLR)  ? reg_wdata[NUM_CH-1:0] : '0;
   assign err_clr = (reg_wr_en && sel == SEL_ERR_CLR) ? reg_wdata[NUM_CH-1:0] : '0;

   dmairq_sticky #(.N(NUM_CH)) u_tc (
      .clk(clk), .rst_n(rst_n), .set_i(tc_evt), .clr_i(tc_clr), .bits_o(tc_raw)
   );

   dmairq_sticky #(.N(NUM_CH)) u_err (
      .clk(clk), .rst_n(rst_n), .set_i(err_evt), .clr_i(err_clr), .bits_o(err_raw)
   );

   assign tc_m  = tc_raw & tc_mask;
   assign err_m = err_raw & err_mask;

   dmairq_rdmux #(.N(NUM_CH), .DW(DATA_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_en(reg_rd_en), .sel(sel),
      .tc_m(tc_m), .err_m(err_m), .rdata(reg_rdata)
   );

   dmairq_irq #(.N(NUM_CH), .IRQ_REG(IRQ_REG)) u_irq (
      .clk(clk), .rst_n(rst_n), .pend_i(tc_m | err_m), .irq_o(irq_out)
   );

   // R12
   ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && (sel == SEL_ALL || sel == SEL_TC || sel == SEL_ERR)
       && tc_evt == '0 && err_evt == '0)
      |=> ($stable(tc_raw) && $stable(err_raw)));

endmodule

// File: tb/sim_dma_irq_collector.sv
`timescale 1ns/1ps
module sim_dma_irq_collector;

   localparam int NCH = 8;
   localparam int AW  = 5;
   localparam int DW  = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr_en = 1'b0;
   logic          reg_rd_en = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [NCH-1:0] tc_evt = '0;
   logic [NCH-1:0] err_evt = '0;
   logic [NCH-1:0] tc_mask = '1;
   logic [NCH-1:0] err_mask = '1;
   logic          irq_out;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   dma_irq_collector #(.NUM_CH(NCH), .ADDR_W(AW), .DATA_W(DW), .IRQ_REG(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tc_evt(tc_evt), .err_evt(err_evt), .tc_mask(tc_mask), .err_mask(err_mask),
      .irq_out(irq_out)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0; reg_wdata = '0;
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      reg_rd_en = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd_en = 1'b0;
      d = reg_rdata;
   endtask

   task automatic pulse(input logic [NCH-1:0] t, input logic [NCH-1:0] e);
      @(negedge clk);
      tc_evt = t; err_evt = e;
      @(negedge clk);
      tc_evt = '0; err_evt = '0;
   endtask

   task automatic clear_all();
      bus_write(5'h08, 32'hFF);
      bus_write(5'h10, 32'hFF);
   endtask

   task automatic t_reset();
      logic [DW-1:0] d;
      check("R1 irq", {31'b0, irq_out}, 32'h0);
      bus_read(5'h00, d); check("R1 all", d, 32'h0);
      bus_read(5'h04, d); check("R1 tc",  d, 32'h0);
      bus_read(5'h0C, d); check("R1 err", d, 32'h0);
   endtask

   task automatic t_irq();
      pulse(8'h01, 8'h00);
      check("R10 lag", {31'b0, irq_out}, 32'h0);
      @(negedge clk);
      check("R10 rise", {31'b0, irq_out}, 32'h1);
      bus_write(5'h08, 32'h01);
      check("R10 hold", {31'b0, irq_out}, 32'h1);
      @(negedge clk);
      check("R10 fall", {31'b0, irq_out}, 32'h0);
   endtask

   task automatic t_status();
      logic [DW-1:0] d;
      pulse(8'h05, 8'h30);
      repeat (4) @(negedge clk);
      bus_read(5'h04, d); check("R2 R3 tc", d, 32'h05);
      bus_read(5'h0C, d); check("R4 err", d, 32'h30);
      bus_read(5'h00, d); check("R5 all", d, 32'h35);
      clear_all();
   endtask

   task automatic t_clear();
      logic [DW-1:0] d;
      pulse(8'hFF, 8'hFF);
      bus_write(5'h08, 32'hFFFF_FF0F);
      bus_read(5'h04, d); check("R6 tc clr", d, 32'hF0);
      bus_read(5'h0C, d); check("R6 err kept", d, 32'hFF);
      bus_write(5'h10, 32'hC3);
      bus_read(5'h0C, d); check("R7 err clr", d, 32'h3C);
      bus_read(5'h04, d); check("R7 tc kept", d, 32'hF0);
      bus_write(5'h08, 32'h00);
      bus_read(5'h04, d); check("R6 zero write", d, 32'hF0);
      clear_all();
      bus_read(5'h00, d); check("R6 R7 all clr", d, 32'h0);
   endtask

   task automatic t_race();
      logic [DW-1:0] d;
      pulse(8'h02, 8'h00);
      @(negedge clk);
      tc_evt = 8'h06; reg_wr_en = 1'b1; reg_addr = 5'h08; reg_wdata = 32'h0A;
      @(negedge clk);
      tc_evt = '0; reg_wr_en = 1'b0; reg_wdata = '0;
      bus_read(5'h04, d); check("R8 tc race", d, 32'h06);
      @(negedge clk);
      err_evt = 8'h10; reg_wr_en = 1'b1; reg_addr = 5'h10; reg_wdata = 32'h10;
      @(negedge clk);
      err_evt = '0; reg_wr_en = 1'b0; reg_wdata = '0;
      bus_read(5'h0C, d); check("R8 err race", d, 32'h10);
      clear_all();
   endtask

   task automatic t_mask();
      logic [DW-1:0] d;
      tc_mask = 8'h00; err_mask = 8'h00;
      pulse(8'h81, 8'h42);
      @(negedge clk);
      check("R9 irq masked", {31'b0, irq_out}, 32'h0);
      bus_read(5'h04, d); check("R9 tc masked", d, 32'h0);
      bus_read(5'h00, d); check("R9 all masked", d, 32'h0);
      tc_mask = 8'h80;
      bus_read(5'h04, d); check("R9 tc unmask", d, 32'h80);
      check("R9 irq unmask", {31'b0, irq_out}, 32'h1);
      err_mask = 8'h02;
      bus_read(5'h0C, d); check("R9 err unmask", d, 32'h02);
      bus_read(5'h00, d); check("R9 all unmask", d, 32'h82);
      tc_mask = '1; err_mask = '1;
   endtask

   task automatic t_ro();
      logic [DW-1:0] d;
      bus_write(5'h00, 32'hFF);
      bus_write(5'h04, 32'hFF);
      bus_write(5'h0C, 32'hFF);
      bus_read(5'h04, d); check("R12 tc", d, 32'h81);
      bus_read(5'h0C, d); check("R12 err", d, 32'h42);
      bus_read(5'h08, d); check("R11 tc clr read", d, 32'h0);
      bus_read(5'h10, d); check("R11 err clr read", d, 32'h0);
      bus_read(5'h14, d); check("R11 unmapped", d, 32'h0);
      bus_read(5'h1C, d); check("R11 unmapped hi", d, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_irq();
      t_status();
      t_clear();
      t_race();
      t_mask();
      t_ro();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule